// File: doc/BRIEF.md
# Inter-processor signal interrupt controller

This block lets processors raise numbered signals at one another and gathers the signals arriving at the local processor onto one interrupt line. Every signal is a (client, signal) pair. Software names a pair by writing a packed 32-bit ID word to a register on a simple word-wide register bus. Depending on the register, that write sends the pair to a remote client, enables or disables its reception, or clears its pending state. A further register clears every pending signal from one client at once.

Incoming requests arrive as one request bit per flattened pair. Each pair has a pending latch and an enable bit. A read-only ID register returns the pending, enabled pair with the lowest flattened index, or all ones when there is none. The summary interrupt is a level. An interrupt handler reads the ID, clears it, and repeats until it reads all ones.

Top module: `ipsig_ctrl`

## Requirements
- R1: An ID word holds the client number in bits 31:16 and the signal number in bits 15:0. The flattened index is client * N_SIGNALS + signal, and bit k of `rx_req` belongs to flattened index k.
- R2: A bus write to offset 0x0C with an in-range ID word raises `tx_strobe` for exactly the cycle after the write edge, with `tx_id` equal to the written word.
- R3: A request bit on `rx_req` sets that pair's pending latch even while the pair is disabled. A disabled pending pair is neither reported nor drives `irq` until it is enabled.
- R4: A write to offset 0x14 enables reception of the named pair and a write to 0x18 disables it, taking effect from the write edge. Disabling leaves the pending latch unchanged.
- R5: A write to offset 0x1C clears the pending latch of the named pair.
- R6: A write to offset 0x38 clears the pending latches of every signal of the client in bits 31:16. Bits 15:0 are ignored.
- R7: A read at offset 0x10 returns the ID word of the pending, enabled pair with the lowest flattened index, or 0xFFFFFFFF when there is none. Reads at other offsets return zero, and read data is combinational from the address.
- R8: `irq` is active high and stays high exactly while at least one enabled pair is pending.
- R9: When a request and a clear (0x1C or 0x38) hit the same pair in the same cycle, the pair stays pending.
- R10: Writes to 0x0C, 0x14, 0x18 or 0x1C whose client or signal number is out of range, and writes to 0x38 whose client is out of range, change no state and raise no strobe.
- R11: After reset all enables and pending latches are zero, `irq` and `tx_strobe` are low, and offset 0x10 reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data (ID word) |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| rx_req | input | N_CLIENTS*N_SIGNALS | Incoming signal requests, one bit per flattened pair |
| tx_strobe | output | 1 | One-cycle pulse for an outgoing signal |
| tx_id | output | 32 | ID word of the outgoing signal |
| irq | output | 1 | Level summary interrupt |

## Verification
A reference model in the bench tracks pending and enable state under random mixes of bus operations and sparse request vectors, with occasional out-of-range IDs. This separates the lowest-index choice from other choices, and separates ignoring bad IDs from decoding them by truncation. Directed sequences raise disabled signals and then enable them, which tells latching apart from dropping. Other directed sequences present two pending pairs in different clients, showing whether the lowest flattened index wins. A request in the same cycle as a clear or client clear shows whether set wins. Disabling and re-enabling shows that the enable is kept apart from the pending latch.

// File: rtl/ipsig_pkg.sv
package ipsig_pkg;

  localparam int unsigned ID_W   = 32;
  localparam int unsigned HALF_W = 16;

  localparam logic [ID_W-1:0] NONE_PENDING = '1;

  typedef enum logic [7:0] {
    OFF_SEND  = 8'h0C,
    OFF_RECV  = 8'h10,
    OFF_ENA   = 8'h14,
    OFF_DIS   = 8'h18,
    OFF_CLR   = 8'h1C,
    OFF_CCLR  = 8'h38
  } reg_off_e;

  typedef struct packed {
    logic [HALF_W-1:0] client;
    logic [HALF_W-1:0] sig;
  } sig_id_t;

  function automatic logic [ID_W-1:0] pack_id(input logic [HALF_W-1:0] c,
                                              input logic [HALF_W-1:0] s);
    sig_id_t w;
    w.client = c;
    w.sig    = s;
    return w;
  endfunction

endpackage

// File: rtl/ipsig_regif.sv
module ipsig_regif
  import ipsig_pkg::*;
#(
  parameter int unsigned N_CLIENTS = 4,
  parameter int unsigned N_SIGNALS = 8,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned N        = N_CLIENTS * N_SIGNALS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ID_W-1:0]   bus_wdata,
  output logic [N-1:0]      en_set_vec,
  output logic [N-1:0]      en_clr_vec,
  output logic [N-1:0]      pend_clr_vec,
  output logic              id_ok,
  output logic              tx_strobe,
  output logic [ID_W-1:0]   tx_id
);

  sig_id_t wid;
  logic    cli_ok;
  logic    wr_send, wr_ena, wr_dis, wr_clr, wr_cclr;
  logic    send_ok;

  assign wid     = sig_id_t'(bus_wdata);
  assign cli_ok  = (32'(wid.client) < N_CLIENTS);
  assign id_ok   = cli_ok && (32'(wid.sig) < N_SIGNALS);

  assign wr_send = bus_wr && (bus_addr == ADDR_W'(OFF_SEND));
  assign wr_ena  = bus_wr && (bus_addr == ADDR_W'(OFF_ENA));
  assign wr_dis  = bus_wr && (bus_addr == ADDR_W'(OFF_DIS));
  assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(OFF_CLR));
  assign wr_cclr = bus_wr && (bus_addr == ADDR_W'(OFF_CCLR));
  assign send_ok = wr_send && id_ok;

  // One-hot decode per pair; an out-of-range ID matches no pair.
  for (genvar c = 0; c < N_CLIENTS; c++) begin : g_cli
    for (genvar s = 0; s < N_SIGNALS; s++) begin : g_sig
      localparam int unsigned K = c * N_SIGNALS + s;
      logic hit, cli_hit;
      assign cli_hit = (32'(wid.client) == c);
      assign hit     = cli_hit && (32'(wid.sig) == s);
      assign en_set_vec[K]   = wr_ena && hit;
      assign en_clr_vec[K]   = wr_dis && hit;
      assign pend_clr_vec[K] = (wr_clr && hit) || (wr_cclr && cli_hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_strobe <= 1'b0;
      tx_id     <= '0;
    end else begin
      tx_strobe <= send_ok;
      if (send_ok) tx_id <= bus_wdata;
    end
  end

  a_r2_send_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    send_ok |=> tx_strobe && (tx_id == $past(bus_wdata)));

  a_r10_send_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_send && !id_ok) |=> !tx_strobe);

endmodule

// File: rtl/ipsig_latch_array.sv
module ipsig_latch_array #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_vec,
  input  logic [N-1:0] en_set_vec,
  input  logic [N-1:0] en_clr_vec,
  input  logic [N-1:0] pend_clr_vec,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] en_q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        // A request overrides a clear in the same cycle.
        if (req_vec[i])           pend_q[i] <= 1'b1;
        else if (pend_clr_vec[i]) pend_q[i] <= 1'b0;
        if (en_set_vec[i])        en_q[i]   <= 1'b1;
        else if (en_clr_vec[i])   en_q[i]   <= 1'b0;
      end
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      req_vec[i] |=> pend_q[i]);

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr_vec[i] && !req_vec[i]) |=> !pend_q[i]);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_vec[i] && !pend_clr_vec[i]) |=> (pend_q[i] == $past(pend_q[i])));

    a_r4_enable: assert property (@(posedge clk) disable iff (!rst_n)
      en_set_vec[i] |=> en_q[i]);

    a_r4_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (en_clr_vec[i] && !en_set_vec[i]) |=> !en_q[i]);
  end

endmodule

// File: rtl/ipsig_lowest_pick.sv
module ipsig_lowest_pick #(
  parameter int unsigned N  = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] pick_idx
);

  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (v[k]) r = IW'(k);
    end
    return r;
  endfunction

  assign found    = |cand;
  assign pick_idx = lowest_set(cand);

  logic [N-1:0] below_mask;
  assign below_mask = (N'(1) << pick_idx) - N'(1);

  a_r7_pick_valid: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> cand[pick_idx]);

  a_r7_pick_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((cand & below_mask) == '0));

endmodule

// File: rtl/ipsig_ctrl.sv
module ipsig_ctrl
  import ipsig_pkg::*;
#(
  parameter int unsigned N_CLIENTS = 4,
  parameter int unsigned N_SIGNALS = 8,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned N        = N_CLIENTS * N_SIGNALS,
  localparam int unsigned IW       = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N-1:0]      rx_req,
  output logic              tx_strobe,
  output logic [31:0]       tx_id,
  output logic              irq
);

  logic [N-1:0]  en_set_vec, en_clr_vec, pend_clr_vec;
  logic [N-1:0]  pend_q, en_q, live_vec;
  logic          id_ok, found;
  logic [IW-1:0] pick_idx;
  logic [31:0]   recv_id;

  function automatic logic [31:0] index_to_id(input logic [IW-1:0] idx);
    int unsigned k;
    k = 32'(idx);
    return pack_id(HALF_W'(k / N_SIGNALS), HALF_W'(k % N_SIGNALS));
  endfunction

  ipsig_regif #(
    .N_CLIENTS(N_CLIENTS), .N_SIGNALS(N_SIGNALS), .ADDR_W(ADDR_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_set_vec(en_set_vec), .en_clr_vec(en_clr_vec),
    .pend_clr_vec(pend_clr_vec), .id_ok(id_ok),
    .tx_strobe(tx_strobe), .tx_id(tx_id)
  );

  ipsig_latch_array #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .req_vec(rx_req), .en_set_vec(en_set_vec),
    .en_clr_vec(en_clr_vec), .pend_clr_vec(pend_clr_vec),
    .pend_q(pend_q), .en_q(en_q)
  );

  assign live_vec = pend_q & en_q;

  ipsig_lowest_pick #(.N(N)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand(live_vec),
    .found(found), .pick_idx(pick_idx)
  );

  assign recv_id   = found ? index_to_id(pick_idx) : NONE_PENDING;
  assign bus_rdata = (bus_addr == ADDR_W'(OFF_RECV)) ? recv_id : '0;
  assign irq       = found;

  a_r8_irq_has_id: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (recv_id != NONE_PENDING));

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_q & en_q) != '0));

  a_r10_enable_range: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !id_ok && ((bus_addr == ADDR_W'(OFF_ENA)) ||
                          (bus_addr == ADDR_W'(OFF_DIS)))) |=> $stable(en_q));

endmodule

// File: tb/sim_ipsig_ctrl.sv
module sim_ipsig_ctrl;

  localparam int unsigned NC = 4;
  localparam int unsigned NS = 8;
  localparam int unsigned N  = NC * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = 8'h10;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  rx_req = '0;
  logic          tx_strobe;
  logic [31:0]   tx_id;
  logic          irq;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  logic [N-1:0] m_pend = '0;
  logic [N-1:0] m_en   = '0;
  logic         m_tx   = 1'b0;
  logic [31:0]  m_txid = '0;

  always #10 clk = ~clk;

  ipsig_ctrl #(.N_CLIENTS(NC), .N_SIGNALS(NS), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_req(rx_req),
    .tx_strobe(tx_strobe), .tx_id(tx_id), .irq(irq)
  );

  function automatic logic [31:0] idw(input int unsigned c, input int unsigned s);
    return (c << 16) | (s & 32'hFFFF);
  endfunction

  // Expected ID register: scan pairs in client-major order.
  function automatic logic [31:0] exp_recv();
    for (int unsigned c = 0; c < NC; c++)
      for (int unsigned s = 0; s < NS; s++)
        if (m_pend[c*NS+s] && m_en[c*NS+s]) return idw(c, s);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [N-1:0] rx);
    int unsigned c, s;
    logic ok;
    c = d[31:16];
    s = d[15:0];
    ok = (c < NC) && (s < NS);
    m_tx = 1'b0;
    if (wr) begin
      case (a)
        8'h0C: begin m_tx = ok; if (ok) m_txid = d; end
        8'h14: if (ok) m_en[c*NS+s] = 1'b1;
        8'h18: if (ok) m_en[c*NS+s] = 1'b0;
        8'h1C: if (ok) m_pend[c*NS+s] = 1'b0;
        8'h38: if (c < NC) for (int unsigned j = 0; j < NS; j++) m_pend[c*NS+j] = 1'b0;
        default: ;
      endcase
    end
    m_pend = m_pend | rx;
  endtask

  // Drives at a falling edge, checks at the next falling edge.
  task automatic step(input string tag, input logic wr, input logic [7:0] a,
                      input logic [31:0] d, input logic [N-1:0] rx);
    bus_wr = wr; bus_addr = a; bus_wdata = d; rx_req = rx;
    model(wr, a, d, rx);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h10; rx_req = '0;
    #1;
    check({tag, " R2 tx_strobe"}, {31'b0, tx_strobe}, {31'b0, m_tx});
    if (m_tx) check({tag, " R1 R2 tx_id"}, tx_id, m_txid);
    check({tag, " R7 recv id"}, bus_rdata, exp_recv());
    check({tag, " R8 irq"}, {31'b0, irq}, {31'b0, exp_recv() != 32'hFFFF_FFFF});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    int unsigned cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] addrs [6];
    void'($urandom(32'd2718));
    addrs[0] = 8'h0C; addrs[1] = 8'h14; addrs[2] = 8'h18;
    addrs[3] = 8'h1C; addrs[4] = 8'h38; addrs[5] = 8'h10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 reset id", bus_rdata, 32'hFFFF_FFFF);
    check("R11 reset irq", {31'b0, irq}, 32'd0);
    check("R11 reset tx_strobe", {31'b0, tx_strobe}, 32'd0);

    // R3: disabled pending is latched but hidden
    step("R3 latch disabled", 1'b0, 8'h10, 0, N'(1) << 5);
    check("R3 hidden", bus_rdata, 32'hFFFF_FFFF);
    step("R3 R4 enable", 1'b1, 8'h14, idw(0, 5), '0);
    check("R3 R4 shown", bus_rdata, 32'h0000_0005);
    // R4: disable keeps pending; re-enable shows again
    step("R4 disable", 1'b1, 8'h18, idw(0, 5), '0);
    check("R4 disabled irq", {31'b0, irq}, 32'd0);
    step("R4 reenable", 1'b1, 8'h14, idw(0, 5), '0);
    check("R4 pending kept", bus_rdata, 32'h0000_0005);
    step("R5 clear", 1'b1, 8'h1C, idw(0, 5), '0);
    check("R5 cleared", bus_rdata, 32'hFFFF_FFFF);

    // R7 priority across clients
    step("R7 enable a", 1'b1, 8'h14, idw(2, 3), '0);
    step("R7 enable b", 1'b1, 8'h14, idw(1, 7), (N'(1) << 19) | (N'(1) << 15));
    check("R7 lowest", bus_rdata, 32'h0001_0007);
    step("R5 R7 clear low", 1'b1, 8'h1C, idw(1, 7), '0);
    check("R5 R7 next", bus_rdata, 32'h0002_0003);

    // R6 client clear, low bits ignored
    step("R6 pend more", 1'b1, 8'h14, idw(2, 0), N'(1) << 16);
    step("R6 client clear", 1'b1, 8'h38, 32'h0002_ABCD, '0);
    check("R6 cleared", bus_rdata, 32'hFFFF_FFFF);
    check("R6 irq low", {31'b0, irq}, 32'd0);

    // R9 request beats clear in the same cycle
    step("R9 set", 1'b0, 8'h10, 0, N'(1) << 16);
    step("R9 clr+req", 1'b1, 8'h1C, idw(2, 0), N'(1) << 16);
    check("R9 stays", bus_rdata, 32'h0002_0000);
    step("R9 cclr+req", 1'b1, 8'h38, idw(2, 0), N'(1) << 16);
    check("R9 stays cclr", bus_rdata, 32'h0002_0000);

    // R10 out-of-range writes
    step("R10 clr bad client", 1'b1, 8'h1C, idw(6, 0), '0);
    check("R10 no clear", bus_rdata, 32'h0002_0000);
    step("R10 dis bad sig", 1'b1, 8'h18, idw(2, 8), '0);
    check("R10 no disable", {31'b0, irq}, 32'd1);
    step("R10 ena bad client", 1'b1, 8'h14, idw(4, 1), N'(1) << 1);
    check("R10 no enable", bus_rdata, 32'h0002_0000);
    step("R10 send bad", 1'b1, 8'h0C, idw(0, 9), '0);
    check("R10 no strobe", {31'b0, tx_strobe}, 32'd0);

    // R1 R2 send
    step("R1 R2 send", 1'b1, 8'h0C, idw(3, 6), '0);
    check("R1 R2 id", tx_id, 32'h0003_0006);
    @(negedge clk);
    check("R2 one cycle", {31'b0, tx_strobe}, 32'd0);

    // R7 other offsets read zero
    bus_addr = 8'h14; #1;
    check("R7 other offset", bus_rdata, 32'd0);
    bus_addr = 8'h10;

    // Random mix against the model
    for (int it = 0; it < 600; it++) begin
      logic [7:0]   a;
      int unsigned  c, s;
      logic [N-1:0] rx;
      a = addrs[$urandom % 6];
      c = ($urandom % 8 == 0) ? NC + ($urandom % 3) : $urandom % NC;
      s = ($urandom % 8 == 0) ? NS + ($urandom % 3) : $urandom % NS;
      rx = ($urandom % 3 == 0) ? N'($urandom & $urandom & $urandom) : '0;
      step("rand", ($urandom % 4) != 0, a, idw(c, s), rx);
    end

    finish_run();
  end

endmodule